// File: doc/BRIEF.md
# Encoded 8-bit ALU with Carry-In Source Select

This block is the combinational arithmetic and logic unit of a small datapath. It takes an operand A, already chosen by an upstream register-select multiplexer, and an operand B, the accumulator. A 5-bit function code selects the operation. The code is a mode bit followed by four select bits, and only a sparse set of fixed patterns is legal. A 2-bit carry source field picks the carry that feeds the adder. The choices are constant zero, constant one, the stored carry flag, or the inverse of that flag.

The outputs are the result, a carry-out and zero and negative flags. An illegal-code flag marks any function pattern outside the legal set. The block has no dedicated logic to clear or set the carry. Those two jobs go through the arithmetic path. The sequencer applies the decrement-with-carry code or the increment code to the status value, with the carry source set to the stored flag or to its inverse.

Top module: `enc_alu`

## Requirements
- R1: Function code 5'b11111 drives operand A unchanged onto the result.
- R2: Function code 5'b11010 drives operand B unchanged onto the result.
- R3: Function code 5'b10000 drives the bitwise complement of A.
- R4: Function code 5'b10011 drives an all-zero result.
- R5: Function code 5'b11011 drives A AND B.
- R6: Function code 5'b11110 drives A OR B.
- R7: Function code 5'b01001 drives A + B + cin. Carry-out is bit 8 of the 9-bit sum.
- R8: Function code 5'b01100 drives A + A + cin, a left shift with cin entering bit 0. Carry-out is the old bit 7.
- R9: Function code 5'b00000 drives A + cin. Carry-out is set only when A is 8'hFF and cin is 1.
- R10: Function code 5'b01111 drives A + 8'hFF + cin, which is A minus one plus cin. Carry-out is bit 8 of that sum.
- R11: The carry source field sets cin as follows: 2'b00 gives 0, 2'b01 gives 1, 2'b10 gives the stored carry input, and 2'b11 gives the inverse of the stored carry input.
- R12: For codes R1 to R6, carry-out is 0.
- R13: Zero is 1 exactly when the 8-bit result is 0. Negative equals result bit 7.
- R14: Any other function code gives result 0, carry-out 0 and illegal 1. Illegal is 0 for the codes in R1 to R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 8 | Operand A from the register-select mux |
| opb | input | 8 | Operand B, the accumulator |
| func | input | 5 | Function code {mode, s3, s2, s1, s0} |
| csel | input | 2 | Carry-in source select |
| cflag | input | 1 | Stored carry flag |
| res | output | 8 | Result |
| cout | output | 1 | Carry-out |
| zflag | output | 1 | Result-is-zero flag |
| nflag | output | 1 | Result bit 7 |
| illegal | output | 1 | Function code outside the legal set |

## Verification
Every output is purely combinational, so each result is due within the same cycle as its stimulus, with no register on the path. The bench changes operands, code and carry source on the falling clock edge. It samples the outputs one nanosecond later, long before the next rising edge, so every compare sees settled logic. The sweep covers all 32 function codes, all four carry sources and both stored carry values. Each combination runs over random operands and over the edge operands 0x00, 0xFF and 0x80.

// File: rtl/enc_alu.sv
module enc_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [4:0]   func,
  input  logic [1:0]   csel,
  input  logic         cflag,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         zflag,
  output logic         nflag,
  output logic         illegal
);

  localparam logic [4:0] F_PASSA = 5'b11111;
  localparam logic [4:0] F_PASSB = 5'b11010;
  localparam logic [4:0] F_NOTA  = 5'b10000;
  localparam logic [4:0] F_ZERO  = 5'b10011;
  localparam logic [4:0] F_AND   = 5'b11011;
  localparam logic [4:0] F_OR    = 5'b11110;
  localparam logic [4:0] F_ADD   = 5'b01001;
  localparam logic [4:0] F_DBL   = 5'b01100;
  localparam logic [4:0] F_INC   = 5'b00000;
  localparam logic [4:0] F_DEC   = 5'b01111;

  logic         cin;
  logic [W-1:0] addend;
  logic [W:0]   sum;
  logic         arith;

  always_comb begin
    unique case (csel)
      2'b00:   cin = 1'b0;
      2'b01:   cin = 1'b1;
      2'b10:   cin = cflag;
      default: cin = ~cflag;
    endcase
  end

  always_comb begin
    arith  = 1'b1;
    addend = '0;
    case (func)
      F_ADD:   addend = opb;
      F_DBL:   addend = opa;
      F_INC:   addend = '0;
      F_DEC:   addend = '1;
      default: arith  = 1'b0;
    endcase
  end

  assign sum = {1'b0, opa} + {1'b0, addend} + {{W{1'b0}}, cin};

  always_comb begin
    illegal = 1'b0;
    res     = '0;
    case (func)
      F_PASSA: res = opa;
      F_PASSB: res = opb;
      F_NOTA:  res = ~opa;
      F_ZERO:  res = '0;
      F_AND:   res = opa & opb;
      F_OR:    res = opa | opb;
      F_ADD, F_DBL, F_INC, F_DEC: res = sum[W-1:0];
      default: illegal = 1'b1;
    endcase
  end

  assign cout  = arith & sum[W];
  assign zflag = (res == '0);
  assign nflag = res[W-1];

endmodule

module enc_alu_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [4:0]   func,
  input logic [W-1:0] res,
  input logic         cout,
  input logic         zflag,
  input logic         nflag,
  input logic         illegal
);
  always_comb begin
    if (func == 5'b11111) assert_passa_R1: assert (res == opa);
    if (func == 5'b11010) assert_passb_R2: assert (res == opb);
    if (func[4] && !illegal) assert_logic_nocarry_R12: assert (!cout);
    assert_zero_flag_R13: assert (zflag == (res == '0));
    assert_neg_flag_R13: assert (nflag == res[W-1]);
    if (illegal) assert_illegal_quiet_R14: assert (res == '0 && !cout);
  end
endmodule

bind enc_alu enc_alu_chk #(.W(W)) u_chk (
  .opa(opa), .opb(opb), .func(func), .res(res),
  .cout(cout), .zflag(zflag), .nflag(nflag), .illegal(illegal)
);

// File: tb/sim_enc_alu.sv
module sim_enc_alu;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [7:0] opa, opb, res;
  logic [4:0] func;
  logic [1:0] csel;
  logic       cflag, cout, zflag, nflag, illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  enc_alu u0 (
    .opa(opa), .opb(opb), .func(func), .csel(csel), .cflag(cflag),
    .res(res), .cout(cout), .zflag(zflag), .nflag(nflag), .illegal(illegal)
  );

  function automatic string tag(input logic [4:0] f);
    case (f)
      5'b11111: return "R1";
      5'b11010: return "R2";
      5'b10000: return "R3";
      5'b10011: return "R4";
      5'b11011: return "R5";
      5'b11110: return "R6";
      5'b01001: return "R7";
      5'b01100: return "R8";
      5'b00000: return "R9";
      5'b01111: return "R10";
      default:  return "R14";
    endcase
  endfunction

  task automatic apply(input logic [7:0] a, input logic [7:0] b,
                       input logic [4:0] f, input logic [1:0] cs, input logic cf);
    int c, s, er;
    bit ec, ei;
    @(negedge clk);
    opa = a; opb = b; func = f; csel = cs; cflag = cf;
    #1;
    c = (cs == 2'd0) ? 0 : (cs == 2'd1) ? 1 : (cs == 2'd2) ? int'(cf) : int'(!cf);
    ei = 0; ec = 0; er = 0;
    case (f)
      5'b11111: er = a;
      5'b11010: er = b;
      5'b10000: er = 255 - a;
      5'b10011: er = 0;
      5'b11011: er = a & b;
      5'b11110: er = a | b;
      5'b01001: begin s = a + b + c;   er = s % 256; ec = s > 255; end
      5'b01100: begin s = 2 * a + c;   er = s % 256; ec = s > 255; end
      5'b00000: begin s = a + c;       er = s % 256; ec = s > 255; end
      5'b01111: begin s = a + 255 + c; er = s % 256; ec = s > 255; end
      default:  ei = 1;
    endcase
    checks++;
    if (res !== 8'(er) || cout !== ec || illegal !== ei) begin
      errors++;
      $display("FAIL %s/R11/R12 f=%b cs=%b cf=%b a=%h b=%h: got res=%h c=%b il=%b exp res=%h c=%b il=%b",
               tag(f), f, cs, cf, a, b, res, cout, illegal, 8'(er), ec, ei);
    end
    checks++;
    if (zflag !== (er == 0) || nflag !== (er >= 128)) begin
      errors++;
      $display("FAIL R13 f=%b res=%h: got z=%b n=%b exp z=%b n=%b",
               f, res, zflag, nflag, er == 0, er >= 128);
    end
  endtask

  initial begin
    opa = 0; opb = 0; func = 0; csel = 0; cflag = 0;
    for (int f = 0; f < 32; f++)
      for (int cs = 0; cs < 4; cs++)
        for (int cf = 0; cf < 2; cf++) begin
          apply(8'h00, 8'h00, 5'(f), 2'(cs), 1'(cf));
          apply(8'hFF, 8'hFF, 5'(f), 2'(cs), 1'(cf));
          apply(8'h80, 8'h7F, 5'(f), 2'(cs), 1'(cf));
          apply(8'hFF, 8'h01, 5'(f), 2'(cs), 1'(cf));
          for (int k = 0; k < 16; k++)
            apply(8'($urandom), 8'($urandom), 5'(f), 2'(cs), 1'(cf));
        end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule